// File: doc/BRIEF.md
# Dual X/Y DSP Address Generator

This block produces two data-memory addresses in the same cycle, one for the X memory and one for the Y memory, so a DSP datapath can move a word on each bus at once. Each side keeps two address pointers of its own and one index register of its own. A request names one of that side's two pointers. The address is driven from the pointer's current value, and the pointer is then changed after the access: it is left alone, stepped by one 16-bit word (+2), or advanced by the side's index register. A per-side modulo enable turns the pointer into a circular-buffer pointer. One start/end register pair is shared by both sides.

Pointers, indexes and the modulo bounds are loaded through one configuration write port. Each side reports the value it writes back to its pointer on its own write-back port. Requests flow in through a per-side valid. There is no ready signal: the X and Y buses never contend, so every valid request is taken in the cycle it appears and no back-pressure exists. Addresses and write-back values are combinational from the request, and the stored pointer changes at the next rising clock edge.

Top module: `dsp_xy_agu`

## Requirements
- R1: After reset (active-low `rst_n`), all pointers, index registers and modulo bounds are zero. A request with the hold mode then reads address 0 on either side, and both write-back valids are low whenever no request updates a pointer.
- R2: A configuration write stores `cfg_wdata` with bit 0 cleared into the register named by `cfg_sel`. The codes are 0 = X pointer 0, 1 = X pointer 1, 2 = Y pointer 0, 3 = Y pointer 1, 4 = X index, 5 = Y index, 6 = modulo start, 7 = modulo end. The write takes effect at the next rising edge.
- R3: In the cycle of a request, `x_addr` is the value held in the X pointer chosen by `x_ptr_sel` (0 or 1), and `y_addr` is the value held in the Y pointer chosen by `y_ptr_sel`. The address is the value from before the update, and its bit 0 is always 0.
- R4: Mode codes 0 (hold) and 3 (reserved, treated as hold) leave the selected pointer unchanged and keep the write-back valid low.
- R5: Mode 1 adds 2 to the selected pointer after the access.
- R6: Mode 2 adds the side's own index register (X index for X, Y index for Y) to the selected pointer, modulo 2^AW, with bit 0 cleared.
- R7: When a side's modulo enable is high and an updating request's old pointer equals the modulo end, the pointer is loaded with the modulo start instead of being stepped.
- R8: With the modulo enable low, a pointer equal to the modulo end steps normally and does not wrap.
- R9: X and Y requests in the same cycle each update their own pointer. Each reports its new value on its own write-back port (valid, pointer select, data) in the request cycle.
- R10: If a configuration write targets the same pointer that a request updates in that cycle, the configuration value is stored and that side's write-back valid is low.
- R11: `x_addr_valid`/`y_addr_valid` follow the side's request valid in the same cycle. Without a request the side's pointers do not change, whatever the mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register code (see R2) |
| cfg_wdata | input | AW | Configuration write data |
| x_mod_en | input | 1 | Modulo wrap enable, X side |
| y_mod_en | input | 1 | Modulo wrap enable, Y side |
| x_req_valid | input | 1 | X access request |
| x_ptr_sel | input | 1 | X pointer choice (0/1) |
| x_mode | input | 2 | X update mode: 0 hold, 1 +2, 2 +index, 3 hold |
| y_req_valid | input | 1 | Y access request |
| y_ptr_sel | input | 1 | Y pointer choice (0/1) |
| y_mode | input | 2 | Y update mode, same codes as X |
| x_addr | output | AW | X memory address |
| x_addr_valid | output | 1 | X address valid |
| y_addr | output | AW | Y memory address |
| y_addr_valid | output | 1 | Y address valid |
| x_wb_valid | output | 1 | X pointer write-back valid |
| x_wb_sel | output | 1 | X pointer being written back |
| x_wb_data | output | AW | X pointer new value |
| y_wb_valid | output | 1 | Y pointer write-back valid |
| y_wb_sel | output | 1 | Y pointer being written back |
| y_wb_data | output | AW | Y pointer new value |

## Verification
The hardest case to reach is the modulo wrap, because the pointer must sit exactly on the end bound. The stimulus loads start and end two words apart, places an X pointer on the start, and steps it with +2 until it lands on the end. The next step must then reload the start. The same pointer is next placed on the end with the enable low, to confirm that it steps past. The collision of a configuration write with an update of the same pointer is set up directly, by driving both in one cycle.

// File: rtl/dsp_xy_agu_pkg.sv
package dsp_xy_agu_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_STEP = 2'd1,
    UPD_INDEX = 2'd2,
    UPD_RSVD = 2'd3
  } upd_mode_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned PTRS_PER_SIDE = 2;
  localparam int unsigned NUM_PTRS = NUM_SIDES * PTRS_PER_SIDE;

  localparam logic [2:0] CFG_XIDX = 3'd4;
  localparam logic [2:0] CFG_YIDX = 3'd5;
  localparam logic [2:0] CFG_MSTART = 3'd6;
  localparam logic [2:0] CFG_MEND = 3'd7;
endpackage

// File: rtl/dsp_xy_agu_side.sv
module dsp_xy_agu_side
  import dsp_xy_agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          ptr_sel,
  input  logic [1:0]    mode,
  input  logic          mod_en,
  input  logic [AW-1:0] ptr0,
  input  logic [AW-1:0] ptr1,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] mstart,
  input  logic [AW-1:0] mend,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          upd_en,
  output logic          upd_sel,
  output logic [AW-1:0] upd_data
);
  localparam logic [AW-1:0] WORD_STEP = AW'(2);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

  upd_mode_e     mode_e;
  logic [AW-1:0] cur;
  logic [AW-1:0] sum;
  logic          at_end;

  assign mode_e = upd_mode_e'(mode);
  assign cur = ptr_sel ? ptr1 : ptr0;
  assign addr = cur & ALIGN_MASK;
  assign addr_valid = req_valid;
  assign at_end = mod_en && ((cur & ALIGN_MASK) == (mend & ALIGN_MASK));

  always_comb begin
    unique case (mode_e)
      UPD_STEP:  sum = cur + WORD_STEP;
      UPD_INDEX: sum = cur + idx;
      default:   sum = cur;
    endcase
  end

  always_comb begin
    upd_en = req_valid && (mode_e == UPD_STEP || mode_e == UPD_INDEX);
    upd_sel = ptr_sel;
    if (at_end) upd_data = mstart & ALIGN_MASK;
    else        upd_data = sum & ALIGN_MASK;
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr[0] == 1'b0 && upd_data[0] == 1'b0)); // R3
endmodule

// File: rtl/dsp_xy_agu_regbank.sv
module dsp_xy_agu_regbank
  import dsp_xy_agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          x_upd_en,
  input  logic          x_upd_sel,
  input  logic [AW-1:0] x_upd_data,
  input  logic          y_upd_en,
  input  logic          y_upd_sel,
  input  logic [AW-1:0] y_upd_data,
  output logic [AW-1:0] ptr_o [NUM_PTRS],
  output logic [AW-1:0] xidx_o,
  output logic [AW-1:0] yidx_o,
  output logic [AW-1:0] mstart_o,
  output logic [AW-1:0] mend_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

  logic [AW-1:0] ptr_q [NUM_PTRS];
  logic [AW-1:0] xidx_q, yidx_q, mstart_q, mend_q;
  logic [AW-1:0] cfg_aligned;

  assign cfg_aligned = cfg_wdata & ALIGN_MASK;

  for (genvar k = 0; k < NUM_PTRS; k++) begin : g_ptr
    localparam logic [2:0] CODE = 3'(k);
    localparam bit IS_Y = (k >= PTRS_PER_SIDE);
    localparam logic SEL = 1'(k % PTRS_PER_SIDE);
    logic side_hit;
    logic [AW-1:0] side_data;

    if (IS_Y) begin : g_y
      assign side_hit = y_upd_en && (y_upd_sel == SEL);
      assign side_data = y_upd_data;
    end else begin : g_x
      assign side_hit = x_upd_en && (x_upd_sel == SEL);
      assign side_data = x_upd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ptr_q[k] <= '0;
      else if (cfg_we && cfg_sel == CODE)  ptr_q[k] <= cfg_aligned;
      else if (side_hit)                   ptr_q[k] <= side_data;
    end

    assign ptr_o[k] = ptr_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xidx_q <= '0;
      yidx_q <= '0;
      mstart_q <= '0;
      mend_q <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        CFG_XIDX:   xidx_q <= cfg_aligned;
        CFG_YIDX:   yidx_q <= cfg_aligned;
        CFG_MSTART: mstart_q <= cfg_aligned;
        CFG_MEND:   mend_q <= cfg_aligned;
        default: ;
      endcase
    end
  end

  assign xidx_o = xidx_q;
  assign yidx_o = yidx_q;
  assign mstart_o = mstart_q;
  assign mend_o = mend_q;

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !x_upd_en) |=> ($stable(ptr_q[0]) && $stable(ptr_q[1]))); // R4
  AST_X_UPDATE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (x_upd_en && !x_upd_sel && !(cfg_we && cfg_sel == 3'd0))
      |=> ptr_q[0] == $past(x_upd_data)); // R9
  AST_Y_UPDATE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (y_upd_en && y_upd_sel && !(cfg_we && cfg_sel == 3'd3))
      |=> ptr_q[3] == $past(y_upd_data)); // R9
  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd0) |=> ptr_q[0] == ($past(cfg_wdata) & ALIGN_MASK)); // R10
endmodule

// File: rtl/dsp_xy_agu.sv
module dsp_xy_agu
  import dsp_xy_agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          x_mod_en,
  input  logic          y_mod_en,
  input  logic          x_req_valid,
  input  logic          x_ptr_sel,
  input  logic [1:0]    x_mode,
  input  logic          y_req_valid,
  input  logic          y_ptr_sel,
  input  logic [1:0]    y_mode,
  output logic [AW-1:0] x_addr,
  output logic          x_addr_valid,
  output logic [AW-1:0] y_addr,
  output logic          y_addr_valid,
  output logic          x_wb_valid,
  output logic          x_wb_sel,
  output logic [AW-1:0] x_wb_data,
  output logic          y_wb_valid,
  output logic          y_wb_sel,
  output logic [AW-1:0] y_wb_data
);
  logic [AW-1:0] ptr_w [NUM_PTRS];
  logic [AW-1:0] xidx_w, yidx_w, mstart_w, mend_w;
  logic          x_upd_en, y_upd_en;
  logic          x_upd_sel, y_upd_sel;
  logic [AW-1:0] x_upd_data, y_upd_data;
  logic          x_cfg_clash, y_cfg_clash;

  dsp_xy_agu_side #(.AW(AW)) u_side_x (
    .clk(clk), .rst_n(rst_n),
    .req_valid(x_req_valid), .ptr_sel(x_ptr_sel), .mode(x_mode), .mod_en(x_mod_en),
    .ptr0(ptr_w[0]), .ptr1(ptr_w[1]), .idx(xidx_w),
    .mstart(mstart_w), .mend(mend_w),
    .addr(x_addr), .addr_valid(x_addr_valid),
    .upd_en(x_upd_en), .upd_sel(x_upd_sel), .upd_data(x_upd_data)
  );

  dsp_xy_agu_side #(.AW(AW)) u_side_y (
    .clk(clk), .rst_n(rst_n),
    .req_valid(y_req_valid), .ptr_sel(y_ptr_sel), .mode(y_mode), .mod_en(y_mod_en),
    .ptr0(ptr_w[2]), .ptr1(ptr_w[3]), .idx(yidx_w),
    .mstart(mstart_w), .mend(mend_w),
    .addr(y_addr), .addr_valid(y_addr_valid),
    .upd_en(y_upd_en), .upd_sel(y_upd_sel), .upd_data(y_upd_data)
  );

  assign x_cfg_clash = cfg_we && (cfg_sel == {2'b00, x_upd_sel});
  assign y_cfg_clash = cfg_we && (cfg_sel == {2'b01, y_upd_sel});

  assign x_wb_valid = x_upd_en && !x_cfg_clash;
  assign x_wb_sel = x_upd_sel;
  assign x_wb_data = x_upd_data;
  assign y_wb_valid = y_upd_en && !y_cfg_clash;
  assign y_wb_sel = y_upd_sel;
  assign y_wb_data = y_upd_data;

  dsp_xy_agu_regbank #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .x_upd_en(x_wb_valid), .x_upd_sel(x_upd_sel), .x_upd_data(x_upd_data),
    .y_upd_en(y_wb_valid), .y_upd_sel(y_upd_sel), .y_upd_data(y_upd_data),
    .ptr_o(ptr_w), .xidx_o(xidx_w), .yidx_o(yidx_w),
    .mstart_o(mstart_w), .mend_o(mend_w)
  );

  AST_X_NO_WB_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !x_req_valid |-> !x_wb_valid); // R11
  AST_Y_NO_WB_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !y_req_valid |-> !y_wb_valid); // R11
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (x_addr_valid == x_req_valid) && (y_addr_valid == y_req_valid)); // R11
endmodule

// File: tb/dsp_xy_agu_tb.sv
module dsp_xy_agu_tb_top;
  localparam int AW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic x_mod_en = 1'b0, y_mod_en = 1'b0;
  logic x_req_valid = 1'b0, x_ptr_sel = 1'b0;
  logic [1:0] x_mode = '0;
  logic y_req_valid = 1'b0, y_ptr_sel = 1'b0;
  logic [1:0] y_mode = '0;
  logic [AW-1:0] x_addr, y_addr, x_wb_data, y_wb_data;
  logic x_addr_valid, y_addr_valid, x_wb_valid, y_wb_valid, x_wb_sel, y_wb_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_xy_agu #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .x_mod_en(x_mod_en), .y_mod_en(y_mod_en),
    .x_req_valid(x_req_valid), .x_ptr_sel(x_ptr_sel), .x_mode(x_mode),
    .y_req_valid(y_req_valid), .y_ptr_sel(y_ptr_sel), .y_mode(y_mode),
    .x_addr(x_addr), .x_addr_valid(x_addr_valid),
    .y_addr(y_addr), .y_addr_valid(y_addr_valid),
    .x_wb_valid(x_wb_valid), .x_wb_sel(x_wb_sel), .x_wb_data(x_wb_data),
    .y_wb_valid(y_wb_valid), .y_wb_sel(y_wb_sel), .y_wb_data(y_wb_data)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] code, logic [AW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = code; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // combinational look at a pointer without any clock edge
  task automatic peek(bit side_y, bit sel, output logic [AW-1:0] val);
    if (side_y) begin
      y_req_valid = 1'b1; y_ptr_sel = sel; y_mode = 2'd0;
      #1 val = y_addr;
      y_req_valid = 1'b0;
    end else begin
      x_req_valid = 1'b1; x_ptr_sel = sel; x_mode = 2'd0;
      #1 val = x_addr;
      x_req_valid = 1'b0;
    end
    #1;
  endtask

  task automatic x_step(string req, bit sel, logic [1:0] mode,
                        logic [AW-1:0] exp_addr, logic exp_wbv, logic [AW-1:0] exp_wb);
    @(negedge clk);
    x_req_valid = 1'b1; x_ptr_sel = sel; x_mode = mode;
    #1;
    check(req, "x_addr", x_addr, exp_addr);
    check(req, "x_wb_valid", x_wb_valid, exp_wbv);
    if (exp_wbv) check(req, "x_wb_data", x_wb_data, exp_wb);
    @(negedge clk);
    x_req_valid = 1'b0; x_mode = 2'd0;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    #2;
    check("R1", "x_wb_valid idle", x_wb_valid, 1'b0);
    check("R1", "y_wb_valid idle", y_wb_valid, 1'b0);
    check("R11", "x_addr_valid idle", x_addr_valid, 1'b0);
    for (int k = 0; k < 4; k++) begin
      peek(k >= 2, k[0], v);
      check("R1", "pointer after reset", v, 16'h0000);
    end
  endtask

  task automatic t_config();
    logic [AW-1:0] v;
    cfg_write(3'd0, 16'h1001);
    cfg_write(3'd1, 16'h2000);
    cfg_write(3'd2, 16'h3000);
    cfg_write(3'd3, 16'h4002);
    peek(1'b0, 1'b0, v); check("R2", "XP0 bit0 cleared", v, 16'h1000);
    peek(1'b0, 1'b1, v); check("R3", "XP1 select", v, 16'h2000);
    peek(1'b1, 1'b0, v); check("R3", "YP0 select", v, 16'h3000);
    peek(1'b1, 1'b1, v); check("R3", "YP1 select", v, 16'h4002);
  endtask

  task automatic t_hold_and_step();
    logic [AW-1:0] v;
    x_step("R4", 1'b0, 2'd0, 16'h1000, 1'b0, '0);
    x_step("R4", 1'b0, 2'd3, 16'h1000, 1'b0, '0);
    peek(1'b0, 1'b0, v); check("R4", "hold keeps XP0", v, 16'h1000);
    x_step("R5", 1'b0, 2'd1, 16'h1000, 1'b1, 16'h1002);
    peek(1'b0, 1'b0, v); check("R5", "XP0 after +2", v, 16'h1002);
    peek(1'b0, 1'b1, v); check("R5", "XP1 untouched", v, 16'h2000);
  endtask

  task automatic t_index_dual();
    logic [AW-1:0] v;
    cfg_write(3'd4, 16'h0010);
    cfg_write(3'd5, 16'hFFFC);
    @(negedge clk);
    x_req_valid = 1'b1; x_ptr_sel = 1'b1; x_mode = 2'd2;
    y_req_valid = 1'b1; y_ptr_sel = 1'b0; y_mode = 2'd2;
    #1;
    check("R9", "x_addr old", x_addr, 16'h2000);
    check("R9", "y_addr old", y_addr, 16'h3000);
    check("R9", "x_wb_valid", x_wb_valid, 1'b1);
    check("R9", "y_wb_valid", y_wb_valid, 1'b1);
    check("R9", "x_wb_sel", x_wb_sel, 1'b1);
    check("R9", "y_wb_sel", y_wb_sel, 1'b0);
    check("R6", "x_wb_data +XIDX", x_wb_data, 16'h2010);
    check("R6", "y_wb_data +YIDX", y_wb_data, 16'h2FFC);
    @(negedge clk);
    x_req_valid = 1'b0; y_req_valid = 1'b0; x_mode = 2'd0; y_mode = 2'd0;
    peek(1'b0, 1'b1, v); check("R6", "XP1 stored", v, 16'h2010);
    peek(1'b1, 1'b0, v); check("R6", "YP0 stored", v, 16'h2FFC);
    peek(1'b1, 1'b1, v); check("R9", "YP1 untouched", v, 16'h4002);
  endtask

  task automatic t_modulo();
    logic [AW-1:0] v;
    cfg_write(3'd6, 16'h0100);
    cfg_write(3'd7, 16'h0104);
    cfg_write(3'd0, 16'h0100);
    x_mod_en = 1'b1;
    x_step("R7", 1'b0, 2'd1, 16'h0100, 1'b1, 16'h0102);
    x_step("R7", 1'b0, 2'd1, 16'h0102, 1'b1, 16'h0104);
    x_step("R7", 1'b0, 2'd1, 16'h0104, 1'b1, 16'h0100);
    peek(1'b0, 1'b0, v); check("R7", "XP0 wrapped", v, 16'h0100);
    x_mod_en = 1'b0;
    cfg_write(3'd0, 16'h0104);
    x_step("R8", 1'b0, 2'd1, 16'h0104, 1'b1, 16'h0106);
    peek(1'b0, 1'b0, v); check("R8", "XP0 no wrap", v, 16'h0106);
  endtask

  task automatic t_clash_and_idle();
    logic [AW-1:0] v;
    @(negedge clk);
    x_req_valid = 1'b1; x_ptr_sel = 1'b0; x_mode = 2'd1;
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h4000;
    #1;
    check("R10", "x_wb_valid on clash", x_wb_valid, 1'b0);
    @(negedge clk);
    x_req_valid = 1'b0; x_mode = 2'd0; cfg_we = 1'b0;
    peek(1'b0, 1'b0, v); check("R10", "config wins", v, 16'h4000);
    @(negedge clk);
    x_req_valid = 1'b0; x_mode = 2'd1; y_mode = 2'd2;
    #1;
    check("R11", "x_addr_valid no req", x_addr_valid, 1'b0);
    check("R11", "y_addr_valid no req", y_addr_valid, 1'b0);
    check("R11", "x_wb_valid no req", x_wb_valid, 1'b0);
    @(negedge clk);
    x_mode = 2'd0; y_mode = 2'd0;
    peek(1'b0, 1'b0, v); check("R11", "XP0 idle keeps", v, 16'h4000);
    peek(1'b1, 1'b0, v); check("R11", "YP0 idle keeps", v, 16'h2FFC);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_hold_and_step();
    t_index_dual();
    t_modulo();
    t_clash_and_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule